// File: doc/BRIEF.md
# Buffered UART Receiver with Error Flags

This block is the receive half of an asynchronous serial port. It watches a serial input line at sixteen times the bit rate, recognises the falling edge of a start bit, confirms it halfway through the bit, and then collects 7 or 8 data bits, least significant first. An optional parity bit and one or two stop bits follow. The finished character moves into a holding register, so software has a full character time to read it while the next one is already arriving.

Status comes from four flags and an interrupt pulse. The buffer-full flag, the parity, framing and overrun errors, and the interrupt are all updated at the centre of the first stop bit. This also holds in two-stop-bit mode. A read strobe takes the character and clears buffer-full. The error flags stay set until a separate clear strobe. The oversampling tick comes from an external baud generator, and the configuration inputs are assumed steady for the length of a frame.

Top module: `rx_frame_buf`

## Requirements
- R1: After reset, data_o is 0x00 and full_o, ovr_o, perr_o, ferr_o and irq_o are all 0.
- R2: A start is accepted only when the line, having been high, is low at a tick and still low 8 ticks later. A low pulse shorter than that returns the receiver to idle, and no character is delivered.
- R3: With cfg_len8_i=1, the 8 bits that follow the start bit, each sampled at tick 8 of its 16-tick period, appear on data_o with the first received bit in data_o[0].
- R4: With cfg_len8_i=0, 7 data bits are received into data_o[6:0] and data_o[7] reads 0.
- R5: When cfg_par_en_i=1, one parity bit follows the data. With cfg_par_odd_i=0 the data bits plus the parity bit must hold an even number of ones, and with cfg_par_odd_i=1 an odd number. A mismatch sets perr_o. When cfg_par_en_i=0, no parity bit is expected.
- R6: When a character completes with the buffer empty, full_o rises and irq_o pulses high for exactly one clock, in the same cycle, at the sample point of the first stop bit.
- R7: A one-cycle rd_i pulse clears full_o on the next clock edge, unless a character completes in that same cycle.
- R8: If a character completes while full_o is set and no read is in progress, ovr_o is set, data_o keeps the old character, full_o stays 1 and irq_o does not pulse.
- R9: ferr_o is set when the first stop bit is sampled low. When cfg_stop2_i=1, the second stop bit is not checked, and full_o and the flags are already updated before the second stop bit begins.
- R10: ovr_o, perr_o and ferr_o remain set across later good characters until a one-cycle err_clr_i pulse clears them.
- R11: The held character can be read while the next character is being received, and that next character then loads normally without overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick16_i | input | 1 | One-cycle enable at 16x the bit rate |
| rxd_i | input | 1 | Serial receive line, idle high |
| cfg_len8_i | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_par_en_i | input | 1 | Parity bit present |
| cfg_par_odd_i | input | 1 | 1: odd parity, 0: even parity |
| cfg_stop2_i | input | 1 | 1: two stop bits |
| rd_i | input | 1 | Read strobe for the receive buffer |
| err_clr_i | input | 1 | Clears the sticky error flags |
| data_o | output | 8 | Receive buffer contents |
| full_o | output | 1 | Buffer holds an unread character |
| ovr_o | output | 1 | Overrun error, sticky |
| perr_o | output | 1 | Parity error, sticky |
| ferr_o | output | 1 | Framing error, sticky |
| irq_o | output | 1 | Receive interrupt, one-cycle pulse |

## Verification
The bench sends a start pulse that is too short. A receiver that fails to confirm the start bit at mid-bit would then deliver a spurious all-ones character. In two-stop-bit mode it checks full_o before the second stop bit and sends a low second stop bit. A design that flags late, or that checks the wrong stop bit, shows up either as no full flag or as a false framing error. The bench also sends a second character into an unread buffer, and reads a character while the next one is arriving. The first case catches a design that overwrites the held data or pulses the interrupt on overrun. The second catches one that reports a false overrun. It also sends 7-bit frames with parity, to catch a stale top bit and parity computed over the wrong bit count.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP1,
    ST_STOP2
  } rx_state_e;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              perr;
    logic              ferr;
  } rx_char_t;
endpackage

// File: rtl/rxb_sync.sv
module rxb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[0] <= 1'b1;
          else         chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[g] <= 1'b1;
          else         chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rxb_frame.sv
module rxb_frame
  import rxb_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tick_i,
  input  logic     rxd_i,
  input  logic     len8_i,
  input  logic     par_en_i,
  input  logic     par_odd_i,
  input  logic     stop2_i,
  output logic     done_o,
  output rx_char_t char_o
);
  localparam int CW   = $clog2(OSR);
  localparam int BW   = $clog2(DATA_W);
  localparam logic [CW-1:0] MID  = CW'(OSR / 2);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  rx_state_e         state_q;
  logic [CW-1:0]     cnt_q;
  logic [BW-1:0]     bit_q;
  logic [DATA_W-1:0] sh_q;
  logic              par_q;
  logic              stop_low_q;
  logic              line_hi_q;
  logic              done_q;
  logic [BW-1:0]     last_bit;
  logic [DATA_W-1:0] data_w;
  logic              at_mid, at_end;

  assign last_bit = len8_i ? BW'(DATA_W - 1) : BW'(DATA_W - 2);
  assign at_mid   = tick_i && (cnt_q == MID);
  assign at_end   = tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      bit_q      <= '0;
      sh_q       <= '0;
      par_q      <= 1'b0;
      stop_low_q <= 1'b0;
      line_hi_q  <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (tick_i) begin
        if (state_q == ST_IDLE) cnt_q <= '0;
        else                    cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
      unique case (state_q)
        ST_IDLE: begin
          if (tick_i) begin
            if (rxd_i) begin
              line_hi_q <= 1'b1;
            end else if (line_hi_q) begin
              // falling edge seen: count from here
              line_hi_q <= 1'b0;
              state_q   <= ST_START;
            end
          end
        end
        ST_START: begin
          if (at_mid && rxd_i) state_q <= ST_IDLE;  // glitch
          else if (at_end) begin
            state_q <= ST_DATA;
            bit_q   <= '0;
          end
        end
        ST_DATA: begin
          if (at_mid) sh_q <= {rxd_i, sh_q[DATA_W-1:1]};
          if (at_end) begin
            if (bit_q == last_bit) state_q <= par_en_i ? ST_PAR : ST_STOP1;
            else                   bit_q   <= bit_q + 1'b1;
          end
        end
        ST_PAR: begin
          if (at_mid) par_q <= rxd_i;
          if (at_end) state_q <= ST_STOP1;
        end
        ST_STOP1: begin
          if (at_mid) begin
            done_q     <= 1'b1;
            stop_low_q <= ~rxd_i;
            if (!stop2_i) state_q <= ST_IDLE;
          end else if (at_end) begin
            state_q <= ST_STOP2;
          end
        end
        ST_STOP2: begin
          if (at_mid) state_q <= ST_IDLE;  // second stop not checked
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // 7-bit frames land in the upper bits of the shifter
  assign data_w      = len8_i ? sh_q : {1'b0, sh_q[DATA_W-1:1]};
  assign char_o.data = data_w;
  assign char_o.perr = par_en_i && ((^data_w) ^ par_q ^ par_odd_i);
  assign char_o.ferr = stop_low_q;
  assign done_o      = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R6
  AST_GLITCH_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_START && at_mid && rxd_i) |=> (state_q == ST_IDLE) && !done_o);  // R2
endmodule

// File: rtl/rxb_hold.sv
module rxb_hold
  import rxb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  rx_char_t          char_i,
  input  logic              len8_i,
  input  logic              rd_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o,
  output logic              ovr_o,
  output logic              perr_o,
  output logic              ferr_o,
  output logic              irq_o
);
  logic load;

  assign load = done_i && (!full_o || rd_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      full_o <= 1'b0;
      ovr_o  <= 1'b0;
      perr_o <= 1'b0;
      ferr_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      irq_o <= load;
      if (load) begin
        data_o <= char_i.data;
        full_o <= 1'b1;
      end else if (rd_i) begin
        full_o <= 1'b0;
      end
      // set wins over clear
      ovr_o  <= (ovr_o  && !clr_i) || (done_i && full_o && !rd_i);
      perr_o <= (perr_o && !clr_i) || (done_i && char_i.perr);
      ferr_o <= (ferr_o && !clr_i) || (done_i && char_i.ferr);
    end
  end

  AST_IRQ_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> full_o);  // R6
  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !done_i) |=> !full_o);  // R7
  AST_OVR_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && full_o && !rd_i) |=> ovr_o && full_o && !irq_o && $stable(data_o));  // R8
  AST_TOP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !len8_i && (!full_o || rd_i)) |=> !data_o[DATA_W-1]);  // R4
  AST_PERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (perr_o && !clr_i) |=> perr_o);  // R10
  AST_FERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ferr_o && !clr_i) |=> ferr_o);  // R10
  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && !clr_i) |=> ovr_o);  // R10
endmodule

// File: rtl/rx_frame_buf.sv
module rx_frame_buf
  import rxb_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick16_i,
  input  logic       rxd_i,
  input  logic       cfg_len8_i,
  input  logic       cfg_par_en_i,
  input  logic       cfg_par_odd_i,
  input  logic       cfg_stop2_i,
  input  logic       rd_i,
  input  logic       err_clr_i,
  output logic [7:0] data_o,
  output logic       full_o,
  output logic       ovr_o,
  output logic       perr_o,
  output logic       ferr_o,
  output logic       irq_o
);
  logic     rxd_s;
  logic     done;
  rx_char_t chr;

  rxb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (rxd_s)
  );

  rxb_frame #(.OSR(OSR)) u_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick16_i),
    .rxd_i    (rxd_s),
    .len8_i   (cfg_len8_i),
    .par_en_i (cfg_par_en_i),
    .par_odd_i(cfg_par_odd_i),
    .stop2_i  (cfg_stop2_i),
    .done_o   (done),
    .char_o   (chr)
  );

  rxb_hold u_hold (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .done_i(done),
    .char_i(chr),
    .len8_i(cfg_len8_i),
    .rd_i  (rd_i),
    .clr_i (err_clr_i),
    .data_o(data_o),
    .full_o(full_o),
    .ovr_o (ovr_o),
    .perr_o(perr_o),
    .ferr_o(ferr_o),
    .irq_o (irq_o)
  );
endmodule

// File: tb/rx_frame_buf_tb_top.sv
`timescale 1ns/1ps
module rx_frame_buf_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick16 = 1'b0;
  logic rxd = 1'b1;
  logic len8 = 1'b1, par_en = 1'b0, par_odd = 1'b0, stop2 = 1'b0;
  logic rd = 1'b0, err_clr = 1'b0;
  logic [7:0] data;
  logic full, ovr, perr, ferr, irq;

  typedef struct packed {
    logic [7:0] data;
    logic perr;
    logic ferr;
    logic ovr;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int fails  = 0;
  logic m_full = 1'b0, m_perr = 1'b0, m_ferr = 1'b0, m_ovr = 1'b0;
  logic [1:0] tdiv = '0;

  always #10 clk = ~clk;

  always @(negedge clk) begin
    tdiv   <= tdiv + 1'b1;
    tick16 <= (tdiv == 2'd3);
  end

  rx_frame_buf dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick16_i(tick16), .rxd_i(rxd),
    .cfg_len8_i(len8), .cfg_par_en_i(par_en), .cfg_par_odd_i(par_odd),
    .cfg_stop2_i(stop2), .rd_i(rd), .err_clr_i(err_clr),
    .data_o(data), .full_o(full), .ovr_o(ovr), .perr_o(perr),
    .ferr_o(ferr), .irq_o(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, expv);
    end
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      do @(negedge clk); while (!tick16);
    end
  endtask

  task automatic drive_bit(input logic b);
    rxd = b;
    wait_ticks(16);
  endtask

  // monitor: every interrupt must match the next expected character
  always @(negedge clk) begin
    if (rst_n && irq) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R6: actual unexpected irq data 0x%02h expected none", data);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check("R3 data", data, e.data);
        check("R6 full", {7'd0, full}, 8'd1);
        check("R5 perr", {7'd0, perr}, {7'd0, e.perr});
        check("R9 ferr", {7'd0, ferr}, {7'd0, e.ferr});
        check("R8 ovr", {7'd0, ovr}, {7'd0, e.ovr});
      end
    end
  end

  task automatic pulse_clr();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    m_perr = 1'b0; m_ferr = 1'b0; m_ovr = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] expv);
    @(negedge clk);
    check("R7 full before read", {7'd0, full}, 8'd1);
    check("R7 read data", data, expv);
    rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    m_full = 1'b0;
    check("R7 full after read", {7'd0, full}, 8'd0);
  endtask

  task automatic send(input logic [7:0] d, input logic l8, input logic pe,
                      input logic podd, input logic bad_par, input logic bad_stop,
                      input logic s2, input logic s2_low, input logic clr);
    logic [7:0] de;
    exp_t e;
    len8 = l8; par_en = pe; par_odd = podd; stop2 = s2;
    if (clr) pulse_clr();
    de = l8 ? d : {1'b0, d[6:0]};
    drive_bit(1'b0);
    for (int i = 0; i < (l8 ? 8 : 7); i++) drive_bit(d[i]);
    if (pe) drive_bit((^de) ^ podd ^ bad_par);
    // flags are taken at the first stop bit
    m_perr = m_perr | (pe & bad_par);
    m_ferr = m_ferr | bad_stop;
    if (m_full) begin
      m_ovr = 1'b1;
    end else begin
      m_full = 1'b1;
      e.data = de; e.perr = m_perr; e.ferr = m_ferr; e.ovr = m_ovr;
      exp_q.push_back(e);
    end
    drive_bit(~bad_stop);
    if (s2) begin
      check("R9 full before second stop", {7'd0, full}, 8'd1);
      drive_bit(~s2_low);
    end
    drive_bit(1'b1);
    drive_bit(1'b1);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 data", data, 8'h00);
    check("R1 flags", {3'd0, full, ovr, perr, ferr, irq}, 8'h00);
    rst_n = 1'b1;
    wait_ticks(20);
    check("R1 idle", {3'd0, full, ovr, perr, ferr, irq}, 8'h00);

    // R3 8-bit, no parity
    send(8'hA5, 1, 0, 0, 0, 0, 0, 0, 1); do_read(8'hA5);
    // R5 even / odd / wrong parity
    send(8'h3C, 1, 1, 0, 0, 0, 0, 0, 1); do_read(8'h3C);
    send(8'h3D, 1, 1, 1, 0, 0, 0, 0, 1); do_read(8'h3D);
    send(8'h3C, 1, 1, 0, 1, 0, 0, 0, 1); do_read(8'h3C);
    check("R5 perr set", {7'd0, perr}, 8'd1);
    // R4 7-bit mode, top bit zero
    send(8'hD5, 0, 1, 1, 0, 0, 0, 0, 1); do_read(8'h55);
    send(8'hFF, 0, 0, 0, 0, 0, 0, 0, 1); do_read(8'h7F);

    // R2 short low pulse
    len8 = 1; par_en = 0; stop2 = 0;
    rxd = 1'b0; wait_ticks(5); rxd = 1'b1; wait_ticks(48);
    check("R2 no char after glitch", {7'd0, full}, 8'd0);

    // R9 framing error
    send(8'h81, 1, 0, 0, 0, 1, 0, 0, 1); do_read(8'h81);
    // R9 second stop low not checked
    send(8'h42, 1, 0, 0, 0, 0, 1, 1, 1); do_read(8'h42);
    check("R9 no ferr on second stop", {7'd0, ferr}, 8'd0);

    // R10 sticky parity error
    send(8'h11, 1, 1, 0, 1, 0, 0, 0, 1); do_read(8'h11);
    send(8'h22, 1, 1, 0, 0, 0, 0, 0, 0); do_read(8'h22);
    check("R10 perr sticky", {7'd0, perr}, 8'd1);
    pulse_clr();
    check("R10 perr cleared", {7'd0, perr}, 8'd0);

    // R8 overrun keeps the old character
    send(8'h66, 1, 0, 0, 0, 0, 0, 0, 1);
    send(8'h99, 1, 0, 0, 0, 0, 0, 0, 0);
    check("R8 ovr set", {7'd0, ovr}, 8'd1);
    check("R8 data kept", data, 8'h66);
    do_read(8'h66);
    pulse_clr();
    check("R10 ovr cleared", {7'd0, ovr}, 8'd0);

    // R11 read while next character arrives
    send(8'h12, 1, 0, 0, 0, 0, 0, 0, 1);
    fork
      send(8'h34, 1, 0, 0, 0, 0, 0, 0, 0);
      begin wait_ticks(60); do_read(8'h12); end
    join
    do_read(8'h34);
    check("R11 no overrun", {7'd0, ovr}, 8'd0);
    check("R11 queue drained", 8'(exp_q.size()), 8'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule